// File: doc/BRIEF.md
# Ethernet Frame Statistics Counters

This block keeps per-frame traffic statistics for an Ethernet MAC as a bank of 32-bit counters. Each time a frame completes, the MAC pulses a strobe for one cycle. With the strobe it gives the frame length in bytes and whether the frame was sent or received. The block bumps the matching packet and good-frame counters and adds the length to two octet totals. It also increments exactly one length-class counter: a fragment class below 64 bytes, a 64-byte class, and six wider classes. Transmit and receive statistics live in two separate banks.

Software sees all counters through a simple register port addressed in bytes. A read returns any counter combinationally. A write preloads or clears any counter. This includes the error, collision and drop words, which are ordinary storage here with no update logic of their own.

Top module: `mib_stats_counters`

## Requirements
- R1: On a frame strobe the packet counter and the good-frame counter of the selected bank each rise by 1 on the next clock edge. The transmit bank uses words 1 and 19 (`frm_is_rx`=0). The receive bank uses words 33 and 51 (`frm_is_rx`=1).
- R2: On a frame strobe the length is added to both octet counters of the selected bank. These are words 17 and 29 for transmit and words 49 and 56 for receive.
- R3: A frame shorter than 64 bytes increments the fragment word, which is 7 for transmit and 39 for receive. A frame of exactly 64 bytes increments the 64-byte word, which is 10 for transmit and 42 for receive.
- R4: Longer frames fall into one of six classes: 65..127, 128..255, 256..511, 512..1023, 1024..2047 and 2048 or more. These map to words 11..16 for transmit and 43..48 for receive, in that order. Exactly one class word changes per frame.
- R5: All counters wrap modulo 2^32, both on increment and on octet addition.
- R6: The counter window spans byte addresses 0x200 to 0x2E0 inclusive, and the word index is (address & 0x1FF)/4. A read inside the window returns that word. A read outside it returns 0.
- R7: A write inside the window loads the 32-bit data into the addressed word on the next edge. A write outside the window changes no counter.
- R8: When a write and a frame update hit the same word in the same cycle, the written value is kept. The frame still updates its other words.
- R9: Synchronous reset clears every word to 0. With no strobe and no write, every word holds its value.
- R10: A frame in one direction leaves every word of the other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_done | input | 1 | One-cycle strobe: a frame has completed |
| frm_is_rx | input | 1 | Direction of the frame, 1 = receive, 0 = transmit |
| frm_len | input | 16 | Frame length in bytes |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The bench aims at the edges of every length class: 63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 2047 and 2048 bytes, plus lengths of zero and near 64 K. An off-by-one comparator would move a frame into the neighbouring class, which leaves one class word one short and its neighbour one long. Counters preloaded near 2^32 are used to expose a design that saturates instead of wrapping. The bench also drives a write and a frame onto the same word in one cycle: a design with the wrong priority shows the incremented value instead of the written one. Writes just below and just above the window must leave the full counter sweep unchanged, and reads there must return zero. A mistake in address decoding would alias those writes onto word 0 or word 56.

// File: rtl/mib_stats_pkg.sv
package mib_stats_pkg;

    localparam int CNT_W     = 32;
    localparam int LEN_W     = 16;
    localparam int ADDR_W    = 10;
    localparam int NUM_WORDS = 57;
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam logic [ADDR_W-1:0] WIN_LO = 10'h200;
    localparam logic [ADDR_W-1:0] WIN_HI = 10'h2E0;

    typedef logic [IDX_W-1:0] idx_t;

    // word positions of one direction's statistics
    typedef struct packed {
        idx_t pkt;
        idx_t frag;
        idx_t bin64;
        idx_t oct;
        idx_t ok;
        idx_t oct_ok;
    } bank_map_t;

    typedef enum logic [2:0] {
        BIN_FRAG,
        BIN_64,
        BIN_65_127,
        BIN_128_255,
        BIN_256_511,
        BIN_512_1023,
        BIN_1024_2047,
        BIN_2048_UP
    } size_bin_e;

    function automatic bank_map_t bank_map(input logic rx);
        bank_map_t m;
        if (rx) begin
            m.pkt = idx_t'(33); m.frag = idx_t'(39); m.bin64 = idx_t'(42);
            m.oct = idx_t'(49); m.ok   = idx_t'(51); m.oct_ok = idx_t'(56);
        end else begin
            m.pkt = idx_t'(1);  m.frag = idx_t'(7);  m.bin64 = idx_t'(10);
            m.oct = idx_t'(17); m.ok   = idx_t'(19); m.oct_ok = idx_t'(29);
        end
        return m;
    endfunction

    function automatic size_bin_e size_bin(input logic [LEN_W-1:0] len);
        if (len < LEN_W'(64))        return BIN_FRAG;
        else if (len == LEN_W'(64))  return BIN_64;
        else if (len < LEN_W'(128))  return BIN_65_127;
        else if (len < LEN_W'(256))  return BIN_128_255;
        else if (len < LEN_W'(512))  return BIN_256_511;
        else if (len < LEN_W'(1024)) return BIN_512_1023;
        else if (len < LEN_W'(2048)) return BIN_1024_2047;
        else                         return BIN_2048_UP;
    endfunction

    function automatic idx_t bin_word(input bank_map_t m, input size_bin_e b);
        if (b == BIN_FRAG) return m.frag;
        return m.bin64 + idx_t'(b) - idx_t'(1);
    endfunction

endpackage

// File: rtl/mib_frame_decode.sv
module mib_frame_decode
    import mib_stats_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int LW = LEN_W,
    parameter int NW = NUM_WORDS
) (
    input  logic                   evt_valid,
    input  logic                   evt_rx,
    input  logic [LW-1:0]          evt_len,
    output logic [NW-1:0]          add_en,
    output logic [NW-1:0][CW-1:0]  add_val
);

    bank_map_t     map;
    idx_t          bin_idx;
    logic [CW-1:0] len_ext;

    always_comb begin
        map     = bank_map(evt_rx);
        bin_idx = bin_word(map, size_bin(LEN_W'(evt_len)));
        len_ext = CW'(evt_len);
    end

    for (genvar i = 0; i < NW; i++) begin : g_word
        always_comb begin
            add_en[i]  = 1'b0;
            add_val[i] = '0;
            if (evt_valid) begin
                if (idx_t'(i) == map.pkt || idx_t'(i) == map.ok || idx_t'(i) == bin_idx) begin
                    add_en[i]  = 1'b1;
                    add_val[i] = CW'(1);
                end else if (idx_t'(i) == map.oct || idx_t'(i) == map.oct_ok) begin
                    add_en[i]  = 1'b1;
                    add_val[i] = len_ext;
                end
            end
        end
    end

endmodule

// File: rtl/mib_reg_decode.sv
module mib_reg_decode
    import mib_stats_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NW = NUM_WORDS
) (
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output idx_t          idx,
    output logic [NW-1:0] wr_vec
);

    always_comb begin
        hit = (addr >= AW'(WIN_LO)) && (addr <= AW'(WIN_HI));
        idx = idx_t'(addr[8:2]);
    end

    for (genvar i = 0; i < NW; i++) begin : g_sel
        assign wr_vec[i] = wr && hit && (idx == idx_t'(i));
    end

endmodule

// File: rtl/mib_counter_cell.sv
module mib_counter_cell #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic          add_en,
    input  logic [CW-1:0] add_val,
    output logic [CW-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en)
            q <= wr_data;
        else if (add_en)
            q <= q + add_val;
    end

endmodule

// File: rtl/mib_stats_counters.sv
module mib_stats_counters
    import mib_stats_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int LW = LEN_W,
    parameter int AW = ADDR_W,
    parameter int NW = NUM_WORDS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frm_done,
    input  logic          frm_is_rx,
    input  logic [LW-1:0] frm_len,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [CW-1:0] reg_wdata,
    output logic [CW-1:0] reg_rdata
);

    logic [NW-1:0]         add_en;
    logic [NW-1:0][CW-1:0] add_val;
    logic [NW-1:0]         wr_vec;
    logic [NW-1:0][CW-1:0] cnt_q;
    logic                  win_hit;
    idx_t                  win_idx;

    mib_frame_decode #(.CW(CW), .LW(LW), .NW(NW)) u_fdec (
        .evt_valid (frm_done),
        .evt_rx    (frm_is_rx),
        .evt_len   (frm_len),
        .add_en    (add_en),
        .add_val   (add_val)
    );

    mib_reg_decode #(.AW(AW), .NW(NW)) u_rdec (
        .wr     (reg_wr),
        .addr   (reg_addr),
        .hit    (win_hit),
        .idx    (win_idx),
        .wr_vec (wr_vec)
    );

    for (genvar i = 0; i < NW; i++) begin : g_cnt
        mib_counter_cell #(.CW(CW)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_vec[i]),
            .wr_data (reg_wdata),
            .add_en  (add_en[i]),
            .add_val (add_val[i]),
            .q       (cnt_q[i])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (win_hit && (int'(win_idx) < NW))
            reg_rdata = cnt_q[win_idx];
    end

endmodule

// File: rtl/mib_stats_counters_chk.sv
module mib_stats_counters_chk
    import mib_stats_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int LW = LEN_W,
    parameter int AW = ADDR_W,
    parameter int NW = NUM_WORDS
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  frm_done,
    input logic                  frm_is_rx,
    input logic [LW-1:0]         frm_len,
    input logic                  reg_wr,
    input logic [AW-1:0]         reg_addr,
    input logic [CW-1:0]         reg_wdata,
    input logic [NW-1:0][CW-1:0] cnt_q
);

    logic                  in_win;
    idx_t                  w_idx;
    idx_t                  last_idx;
    logic                  last_rx;
    logic [NW-1:0][CW-1:0] prev_cnt;
    logic [7:0]            bin_chg;

    assign in_win = (reg_addr >= AW'(WIN_LO)) && (reg_addr <= AW'(WIN_HI));
    assign w_idx  = idx_t'(reg_addr[8:2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_idx <= '0;
            last_rx  <= 1'b0;
            prev_cnt <= '0;
        end else begin
            last_idx <= w_idx;
            last_rx  <= frm_is_rx;
            prev_cnt <= cnt_q;
        end
    end

    always_comb begin
        bank_map_t m;
        m = bank_map(last_rx);
        for (int k = 0; k < 8; k++) begin
            idx_t wi;
            wi = bin_word(m, size_bin_e'(k));
            bin_chg[k] = (cnt_q[wi] != prev_cnt[wi]);
        end
    end

    AST_TX_PKT_INC: assert property (@(posedge clk) disable iff (rst)
        (frm_done && !frm_is_rx && !reg_wr) |=> cnt_q[1] == CW'($past(cnt_q[1]) + CW'(1))); // R1

    AST_RX_OCT_ADD: assert property (@(posedge clk) disable iff (rst)
        (frm_done && frm_is_rx && !reg_wr) |=> cnt_q[49] == CW'($past(cnt_q[49]) + CW'($past(frm_len)))); // R2

    AST_ONE_BIN: assert property (@(posedge clk) disable iff (rst)
        (frm_done && !reg_wr) |=> $countones(bin_chg) == 1); // R4

    AST_SW_WINS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && in_win) |=> cnt_q[last_idx] == $past(reg_wdata)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!frm_done && !reg_wr) |=> $stable(cnt_q)); // R9

    AST_TX_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        (frm_done && !frm_is_rx && !reg_wr) |=> $stable(cnt_q[NW-1:32])); // R10

endmodule

bind mib_stats_counters mib_stats_counters_chk #(.CW(CW), .LW(LW), .AW(AW), .NW(NW)) u_chk (.*);

// File: tb/mib_stats_counters_tb_top.sv
module mib_stats_counters_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NWORD = 57;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_done = 1'b0;
    logic        frm_is_rx = 1'b0;
    logic [15:0] frm_len = '0;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_w [NWORD];

    always #(CLK_PERIOD/2) clk = ~clk;

    mib_stats_counters dut_i (
        .clk(clk), .rst(rst), .frm_done(frm_done), .frm_is_rx(frm_is_rx),
        .frm_len(frm_len), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // {rx, length, expected class word}
    localparam logic [22:0] VEC [16] = '{
        {1'b0, 16'd0,     6'd7},  {1'b0, 16'd63,   6'd7},
        {1'b0, 16'd64,    6'd10}, {1'b0, 16'd65,   6'd11},
        {1'b0, 16'd127,   6'd11}, {1'b0, 16'd128,  6'd12},
        {1'b1, 16'd255,   6'd44}, {1'b1, 16'd256,  6'd45},
        {1'b1, 16'd511,   6'd45}, {1'b1, 16'd512,  6'd46},
        {1'b1, 16'd1023,  6'd46}, {1'b1, 16'd1024, 6'd47},
        {1'b1, 16'd2047,  6'd47}, {1'b1, 16'd2048, 6'd48},
        {1'b0, 16'd60000, 6'd16}, {1'b1, 16'd10,   6'd39}
    };

    function automatic int bench_bin(input logic rx, input int len);
        int b;
        if (len < 64)        b = 7;
        else if (len == 64)  b = 10;
        else if (len < 128)  b = 11;
        else if (len < 256)  b = 12;
        else if (len < 512)  b = 13;
        else if (len < 1024) b = 14;
        else if (len < 2048) b = 15;
        else                 b = 16;
        return rx ? b + 32 : b;
    endfunction

    task automatic model_frame(input logic rx, input int len, input int bin);
        int pk, ok, oc, oo;
        pk = rx ? 33 : 1;  ok = rx ? 51 : 19;
        oc = rx ? 49 : 17; oo = rx ? 56 : 29;
        exp_w[pk]  = exp_w[pk] + 32'd1;
        exp_w[ok]  = exp_w[ok] + 32'd1;
        exp_w[oc]  = exp_w[oc] + 32'(len);
        exp_w[oo]  = exp_w[oo] + 32'(len);
        exp_w[bin] = exp_w[bin] + 32'd1;
    endtask

    task automatic send_frame(input logic rx, input logic [15:0] len);
        @(negedge clk);
        frm_done = 1'b1; frm_is_rx = rx; frm_len = len;
        @(negedge clk);
        frm_done = 1'b0;
    endtask

    task automatic sw_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chk_rd(input logic [9:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        n_tests++;
        if (reg_rdata !== e) begin
            n_fail++;
            $display("FAIL %s addr=0x%h actual=0x%h expected=0x%h", tag, a, reg_rdata, e);
        end
    endtask

    task automatic sweep(input string tag);
        for (int w = 0; w < NWORD; w++)
            chk_rd(10'h200 + 10'(w * 4), exp_w[w], tag);
    endtask

    initial begin
        for (int w = 0; w < NWORD; w++) exp_w[w] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        sweep("R9 reset");

        // table walk: R1 R2 R3 R4 R10
        for (int v = 0; v < 16; v++) begin
            logic rx; int len; int bin;
            rx  = VEC[v][22];
            len = int'(VEC[v][21:6]);
            bin = int'(VEC[v][5:0]);
            send_frame(rx, 16'(len));
            model_frame(rx, len, bin);
            chk_rd(10'h200 + 10'(bin * 4), exp_w[bin], (len <= 64) ? "R3 class" : "R4 class");
            chk_rd(rx ? 10'h284 : 10'h204, exp_w[rx ? 33 : 1], "R1 packets");
            chk_rd(rx ? 10'h2E0 : 10'h274, exp_w[rx ? 56 : 29], "R2 octets");
        end
        sweep("R10 bank sweep");

        // R7: preload, then R5 wrap
        sw_write(10'h204, 32'hFFFF_FFFF);
        sw_write(10'h244, 32'hFFFF_FFF0);
        exp_w[1]  = 32'hFFFF_FFFF;
        exp_w[17] = 32'hFFFF_FFF0;
        chk_rd(10'h244, 32'hFFFF_FFF0, "R7 preload");
        send_frame(1'b0, 16'd32);
        model_frame(1'b0, 32, bench_bin(1'b0, 32));
        chk_rd(10'h204, 32'h0, "R5 packet wrap");
        chk_rd(10'h244, 32'h10, "R5 octet wrap");

        // R8: write and frame on the same word in one cycle
        @(negedge clk);
        frm_done = 1'b1; frm_is_rx = 1'b1; frm_len = 16'd300;
        reg_wr = 1'b1; reg_addr = 10'h284; reg_wdata = 32'h55;
        @(negedge clk);
        frm_done = 1'b0; reg_wr = 1'b0;
        model_frame(1'b1, 300, bench_bin(1'b1, 300));
        exp_w[33] = 32'h55;
        chk_rd(10'h284, 32'h55, "R8 write wins");
        chk_rd(10'h2CC, exp_w[51], "R8 other word updated");

        // R6/R7: outside the window
        sw_write(10'h1FC, 32'hDEAD_BEEF);
        sw_write(10'h2E4, 32'hDEAD_BEEF);
        chk_rd(10'h1FC, 32'h0, "R6 below window");
        chk_rd(10'h2E4, 32'h0, "R6 above window");
        sweep("R7 outside write ignored");

        // R9: hold with no activity, then reset clears
        repeat (5) @(negedge clk);
        chk_rd(10'h2E0, exp_w[56], "R9 hold");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int w = 0; w < NWORD; w++) exp_w[w] = '0;
        sweep("R9 reset clear");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule